// File: doc/BRIEF.md
# Spectral Frame Packetizer with Metadata Header

This block turns a byte stream of spectral frames into packets ready to be placed in an Ethernet payload. Each packet starts with a 40-byte metadata header. A fixed number of frames follows the header, six by default. An accumulation is a run of frames whose length is set at its start. When that length is not a multiple of six, the accumulation ends with a short packet that holds only the frames that remain.

The header carries:
- the accumulation length and the packet index within the accumulation;
- a running count of completed accumulations;
- a second count that wraps every 50 accumulations, so software can align to a once-per-second mark;
- four delay settings, the FFT shift setting and the ADC overflow count;
- two source-identity bytes, the board number and a data-kind byte.

For power data the two identity bytes are the antenna and the polarization. For cross-correlation data they are the two antennas of the baseline. A sync pulse restarts the accumulation at the next packet boundary and clears the packet index and the wrapping count. Output bytes carry first-byte and last-byte markers. The payload source is pulled with a ready signal. When the source has nothing to send in mid-packet, the output pauses and no byte is lost.

Top module: `frame_packetizer`

## Requirements
- R1: After reset, out_valid, out_sop, out_eop and in_ready are low. The first packet carries packet index 0, running count 0 and wrapping count 0.
- R2: Each packet starts with a 40-byte header. Multi-byte fields are sent most significant byte first, in this order:
  - byte 0: header length (40);
  - bytes 1-2: accumulation length;
  - byte 3: packet index;
  - bytes 4-7: running accumulation count;
  - bytes 8-11: wrapping count;
  - bytes 12-27: delays 0 to 3, where delay k is taken from delay_i[32k+31:32k];
  - bytes 28-31: FFT shift;
  - bytes 32-35: ADC overflow count;
  - bytes 36, 37, 38, 39: source byte A, source byte B, board, data kind.
- R3: Each packet carries min(FRAMES_PER_PKT, frames left in the accumulation) frames of BEATS_PER_FRAME bytes, so an accumulation yields ceil(length/FRAMES_PER_PKT) packets. An accumulation length of 0 is treated as 1.
- R4: in_ready is high only while payload is being taken. Every byte accepted (in_valid and in_ready) appears unchanged, in order, on out_data one cycle later.
- R5: out_sop is high only on header byte 0. out_eop is high only on the last payload byte of a packet.
- R6: The packet index rises by 1 per packet, wraps from 255 to 0, and restarts at 0 for each new accumulation.
- R7: The running count rises by 1 when the last packet of an accumulation completes.
- R8: The wrapping count steps 0, 1, …, 49, then returns to 0, advancing on the same event as the running count.
- R9: A sync pulse causes the next packet to begin a new accumulation, with packet index 0 and wrapping count 0. The running count is left unchanged, and an accumulation cut short by sync is not counted.
- R10: When in_valid is low during payload, out_valid is low in the following cycle and the packet resumes where it stopped.
- R11: acc_len_i is sampled when an accumulation starts. Later changes do not affect the header length field or the packet sizes of that accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Alignment pulse; takes effect at the next packet start |
| acc_len_i | input | 16 | Frames per accumulation |
| delay_i | input | 128 | Four 32-bit delay settings; delay k in bits 32k+31:32k |
| fft_shift_i | input | 32 | FFT shift setting |
| adc_ovf_i | input | 32 | ADC overflow count |
| src_a_i | input | 8 | Antenna (power) or first antenna (cross) |
| src_b_i | input | 8 | Polarization code (power) or second antenna (cross) |
| board_i | input | 8 | Board/engine number |
| kind_i | input | 8 | Data-kind code (power or cross-correlation) |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block takes payload this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of packet |
| out_eop | output | 1 | Last byte of packet |

## Verification
The bench builds the block with BEATS_PER_FRAME = 2, FRAMES_PER_PKT = 6 and a wrap of 50. A two-byte frame shrinks a packet to 52 bytes. This makes a 1560-frame accumulation of 260 packets short enough to run, so the packet index can be followed through its wrap from 255 to 0. Short frames also make it cheap to run fifty-one single-frame accumulations, which carries the wrapping count through 49 and back to 0. The same setting allows a stall in mid-frame, a length change in mid-accumulation, and a sync that cuts an accumulation short.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

    localparam int HDR_BYTES = 40;
    localparam int HDR_BITS  = HDR_BYTES * 8;
    localparam int HIDX_W    = $clog2(HDR_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2
    } pk_state_e;

    // Per-packet copy of the side-band inputs.
    typedef struct packed {
        logic [0:3][31:0] dly;
        logic [31:0]      fft;
        logic [31:0]      ovf;
        logic [7:0]       src_a;
        logic [7:0]       src_b;
        logic [7:0]       board;
        logic [7:0]       kind;
    } snap_t;

    // Header image, most significant bits sent first.
    typedef struct packed {
        logic [7:0]       hlen;
        logic [15:0]      acc_len;
        logic [7:0]       pnum;
        logic [31:0]      glob;
        logic [31:0]      wrap;
        logic [0:3][31:0] dly;
        logic [31:0]      fft;
        logic [31:0]      ovf;
        logic [7:0]       src_a;
        logic [7:0]       src_b;
        logic [7:0]       board;
        logic [7:0]       kind;
    } pkt_hdr_t;

endpackage

// File: rtl/pkt_acc_track.sv
module pkt_acc_track #(
    parameter int ACC_MOD = 50
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       pkt_done_i,
    input  logic                       acc_done_i,
    output logic [7:0]                 pnum_o,
    output logic [31:0]                glob_o,
    output logic [$clog2(ACC_MOD)-1:0] wrap_o
);
    localparam int MOD_W = $clog2(ACC_MOD);

    typedef struct packed {
        logic [7:0]       pnum;
        logic [31:0]      glob;
        logic [MOD_W-1:0] wrap;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d.pnum = '0;
            cnt_d.wrap = '0;
        end else if (pkt_done_i) begin
            if (acc_done_i) begin
                cnt_d.pnum = '0;
                cnt_d.glob = cnt_q.glob + 32'd1;
                cnt_d.wrap = (cnt_q.wrap == MOD_W'(ACC_MOD - 1)) ? '0 : cnt_q.wrap + 1'b1;
            end else begin
                cnt_d.pnum = cnt_q.pnum + 8'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pnum_o = cnt_q.pnum;
    assign glob_o = cnt_q.glob;
    assign wrap_o = cnt_q.wrap;

    // R6
    pnum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done_i && !acc_done_i && !clr_i) |=> (pnum_o == $past(pnum_o) + 8'd1));

    // R7
    glob_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done_i && acc_done_i && !clr_i) |=> (glob_o == $past(glob_o) + 32'd1) && (pnum_o == 8'd0));

    // R8
    wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(wrap_o) < ACC_MOD));

    // R9
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pnum_o == 8'd0) && (wrap_o == '0) && $stable(glob_o));

endmodule

// File: rtl/pkt_beat_ctr.sv
module pkt_beat_ctr #(
    parameter int BEATS_PER_FRAME = 1024,
    parameter int FRAMES_PER_PKT  = 6,
    parameter int FR_W            = $clog2(FRAMES_PER_PKT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [FR_W-1:0] nfr_i,
    input  logic            step_i,
    output logic            frame_end_o,
    output logic            pkt_end_o
);
    localparam int BEAT_W = (BEATS_PER_FRAME > 1) ? $clog2(BEATS_PER_FRAME) : 1;

    typedef struct packed {
        logic [BEAT_W-1:0] beat;
        logic [FR_W-1:0]   frm;
        logic [FR_W-1:0]   nfr;
    } bc_t;

    bc_t bc_d, bc_q;

    always_comb begin
        frame_end_o = step_i && (bc_q.beat == BEAT_W'(BEATS_PER_FRAME - 1));
        pkt_end_o   = frame_end_o && (bc_q.frm == bc_q.nfr - 1'b1);
        bc_d = bc_q;
        if (load_i) begin
            bc_d.beat = '0;
            bc_d.frm  = '0;
            bc_d.nfr  = nfr_i;
        end else if (step_i) begin
            if (frame_end_o) begin
                bc_d.beat = '0;
                bc_d.frm  = pkt_end_o ? '0 : bc_q.frm + 1'b1;
            end else begin
                bc_d.beat = bc_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bc_q <= '0;
        else        bc_q <= bc_d;
    end

    // R3
    nfr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (nfr_i != '0) && (32'(nfr_i) <= FRAMES_PER_PKT));

endmodule

// File: rtl/pkt_hdr_sel.sv
module pkt_hdr_sel
    import pkt_pkg::*;
(
    input  pkt_hdr_t          hdr_i,
    input  logic [HIDX_W-1:0] idx_i,
    output logic [7:0]        byte_o
);
    logic [HDR_BITS-1:0] shifted;

    always_comb begin
        shifted = hdr_i << (8 * int'(idx_i));
        byte_o  = shifted[HDR_BITS-1 -: 8];
    end

endmodule

// File: rtl/frame_packetizer.sv
module frame_packetizer
    import pkt_pkg::*;
#(
    parameter int FRAMES_PER_PKT  = 6,
    parameter int BEATS_PER_FRAME = 1024,
    parameter int ACC_MOD         = 50
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_i,
    input  logic [15:0]  acc_len_i,
    input  logic [127:0] delay_i,
    input  logic [31:0]  fft_shift_i,
    input  logic [31:0]  adc_ovf_i,
    input  logic [7:0]   src_a_i,
    input  logic [7:0]   src_b_i,
    input  logic [7:0]   board_i,
    input  logic [7:0]   kind_i,
    input  logic         in_valid,
    input  logic [7:0]   in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [7:0]   out_data,
    output logic         out_sop,
    output logic         out_eop
);
    localparam int FR_W  = $clog2(FRAMES_PER_PKT + 1);
    localparam int MOD_W = $clog2(ACC_MOD);

    typedef struct packed {
        pk_state_e         st;
        logic [HIDX_W-1:0] hidx;
        logic [15:0]       left;
        logic [15:0]       acc_len;
        logic              sync_pend;
        snap_t             snap;
        logic              ov;
        logic [7:0]        od;
        logic              sop;
        logic              eop;
    } top_t;

    top_t r_d, r_q;

    logic             start, step, frame_end, pkt_end;
    logic             pkt_done, acc_done, clr;
    logic [FR_W-1:0]  nfr;
    logic [15:0]      len_eff, left_n;
    logic             new_acc;
    logic [7:0]       pnum;
    logic [31:0]      glob;
    logic [MOD_W-1:0] wrap;
    logic [7:0]       hdr_byte;
    pkt_hdr_t         hdr;
    snap_t            snap_in;

    pkt_acc_track #(.ACC_MOD(ACC_MOD)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .pkt_done_i (pkt_done),
        .acc_done_i (acc_done),
        .pnum_o     (pnum),
        .glob_o     (glob),
        .wrap_o     (wrap)
    );

    pkt_beat_ctr #(
        .BEATS_PER_FRAME (BEATS_PER_FRAME),
        .FRAMES_PER_PKT  (FRAMES_PER_PKT),
        .FR_W            (FR_W)
    ) u_beat (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (start),
        .nfr_i       (nfr),
        .step_i      (step),
        .frame_end_o (frame_end),
        .pkt_end_o   (pkt_end)
    );

    pkt_hdr_sel u_sel (
        .hdr_i  (hdr),
        .idx_i  (r_q.hidx),
        .byte_o (hdr_byte)
    );

    // Side-band capture and header image.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            snap_in.dly[k] = delay_i[32*k +: 32];
        end
        snap_in.fft   = fft_shift_i;
        snap_in.ovf   = adc_ovf_i;
        snap_in.src_a = src_a_i;
        snap_in.src_b = src_b_i;
        snap_in.board = board_i;
        snap_in.kind  = kind_i;

        hdr.hlen    = 8'(HDR_BYTES);
        hdr.acc_len = r_q.acc_len;
        hdr.pnum    = pnum;
        hdr.glob    = glob;
        hdr.wrap    = 32'(wrap);
        hdr.dly     = r_q.snap.dly;
        hdr.fft     = r_q.snap.fft;
        hdr.ovf     = r_q.snap.ovf;
        hdr.src_a   = r_q.snap.src_a;
        hdr.src_b   = r_q.snap.src_b;
        hdr.board   = r_q.snap.board;
        hdr.kind    = r_q.snap.kind;
    end

    // Packet sequencing.
    always_comb begin
        r_d      = r_q;
        r_d.ov   = 1'b0;
        r_d.sop  = 1'b0;
        r_d.eop  = 1'b0;
        start    = 1'b0;
        step     = 1'b0;
        pkt_done = 1'b0;
        acc_done = 1'b0;
        clr      = 1'b0;
        in_ready = (r_q.st == ST_PAY);

        len_eff = (acc_len_i == 16'd0) ? 16'd1 : acc_len_i;
        new_acc = (r_q.left == 16'd0) || r_q.sync_pend || sync_i;
        left_n  = new_acc ? len_eff : r_q.left;
        nfr     = (left_n >= 16'(FRAMES_PER_PKT)) ? FR_W'(FRAMES_PER_PKT) : FR_W'(left_n);

        if (sync_i) r_d.sync_pend = 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    start    = 1'b1;
                    r_d.left = left_n;
                    r_d.snap = snap_in;
                    if (new_acc) r_d.acc_len = len_eff;
                    if (r_q.sync_pend || sync_i) begin
                        clr           = 1'b1;
                        r_d.sync_pend = 1'b0;
                    end
                    r_d.hidx = '0;
                    r_d.st   = ST_HDR;
                end
            end
            ST_HDR: begin
                r_d.ov   = 1'b1;
                r_d.od   = hdr_byte;
                r_d.sop  = (r_q.hidx == '0);
                r_d.hidx = r_q.hidx + 1'b1;
                if (r_q.hidx == HIDX_W'(HDR_BYTES - 1)) r_d.st = ST_PAY;
            end
            ST_PAY: begin
                if (in_valid) begin
                    step   = 1'b1;
                    r_d.ov = 1'b1;
                    r_d.od = in_data;
                    if (frame_end) r_d.left = r_q.left - 16'd1;
                    if (pkt_end) begin
                        r_d.eop  = 1'b1;
                        pkt_done = 1'b1;
                        acc_done = (r_q.left == 16'd1);
                        r_d.st   = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.ov;
    assign out_data  = r_q.od;
    assign out_sop   = r_q.sop;
    assign out_eop   = r_q.eop;

    // R4
    pay_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (out_valid && (out_data == $past(in_data))));

    // R10
    pay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> !out_valid);

    // R5
    marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> (out_valid && !(out_sop && out_eop)));

    // R5
    sop_follows_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> !$past(in_ready));

endmodule

// File: tb/tb_frame_packetizer.sv
module tb_frame_packetizer;

    localparam int FPP   = 6;
    localparam int BEATS = 2;
    localparam int WRAP  = 50;
    localparam int HB    = 40;

    localparam int NV = 5;
    localparam int TV_LEN   [NV] = '{1, 6, 7, 13, 12};
    localparam int TV_KIND  [NV] = '{0, 1, 0, 1, 0};
    localparam int TV_A     [NV] = '{3, 1, 5, 2, 7};
    localparam int TV_B     [NV] = '{2, 4, 0, 6, 3};
    localparam int TV_STALL [NV] = '{-1, 5, -1, 9, 13};
    localparam int TV_CHG   [NV] = '{-1, -1, -1, 14, -1};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync_i = 1'b0;
    logic [15:0]  acc_len_i = '0;
    logic [127:0] delay_i = '0;
    logic [31:0]  fft_shift_i = '0;
    logic [31:0]  adc_ovf_i = '0;
    logic [7:0]   src_a_i = '0, src_b_i = '0, board_i = '0, kind_i = '0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = '0;
    logic         in_ready, out_valid, out_sop, out_eop;
    logic [7:0]   out_data;

    frame_packetizer #(
        .FRAMES_PER_PKT (FPP),
        .BEATS_PER_FRAME(BEATS),
        .ACC_MOD        (WRAP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .acc_len_i(acc_len_i),
        .delay_i(delay_i), .fft_shift_i(fft_shift_i), .adc_ovf_i(adc_ovf_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .board_i(board_i), .kind_i(kind_i),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit fin = 1'b0;

    logic [7:0] cap_d [0:16383];
    logic       cap_s [0:16383];
    logic       cap_e [0:16383];
    int wr = 0;
    int rd = 0;

    int m_glob = 0;
    int m_wrap = 0;
    logic [7:0] src_dat = '0;
    logic [7:0] exp_dat = '0;

    initial begin
        forever begin
            @(negedge clk);
            if (out_valid && wr < 16384) begin
                cap_d[wr] = out_data;
                cap_s[wr] = out_sop;
                cap_e[wr] = out_eop;
                wr++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic longint get_be(input int off, input int n);
        longint v = 0;
        for (int i = 0; i < n; i++) v = (v << 8) | longint'(cap_d[off + i]);
        return v;
    endfunction

    task automatic clear_cap();
        @(negedge clk);
        #1;
        wr = 0;
        rd = 0;
    endtask

    task automatic feed(input int n, input int stall_at, input int chg_at);
        int  sent = 0;
        bit  stalled = 1'b0;
        int  w0;
        while (sent < n) begin
            @(negedge clk);
            if (sent == stall_at && !stalled && in_ready) begin
                stalled  = 1'b1;
                in_valid = 1'b0;
                repeat (2) @(negedge clk);
                #1 w0 = wr;
                repeat (4) @(negedge clk);
                #1;
                // R10: no output while the source is idle mid-payload
                chk(wr == w0 && !out_valid, "R10 stall", wr, w0);
                @(negedge clk);
            end
            if (sent == chg_at) acc_len_i = 16'd99;
            in_valid = 1'b1;
            in_data  = src_dat;
            if (in_ready) begin
                sent++;
                src_dat = src_dat + 8'd1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_packet(input int len_field, input int pnum, input int frames);
        int len = HB + frames * BEATS;
        int e = rd;
        int mism = 0;
        int first_bad = -1;
        logic [HB*8-1:0] ev;
        while (e < wr && !cap_e[e]) e++;
        // R3: packet length from first byte to eop marker
        chk(e - rd + 1 == len, "R3 packet length", e - rd + 1, len);
        mism = (cap_s[rd] !== 1'b1) ? 1 : 0;
        for (int i = 1; i < len; i++) if (cap_s[rd + i] !== 1'b0) mism++;
        for (int i = 0; i < len - 1; i++) if (cap_e[rd + i] !== 1'b0) mism++;
        if (cap_e[rd + len - 1] !== 1'b1) mism++;
        // R5: markers exactly on first and last byte
        chk(mism == 0, "R5 sop/eop placement", mism, 0);
        // R6
        chk(get_be(rd + 3, 1) == longint'(pnum & 255), "R6 packet index", get_be(rd + 3, 1), pnum & 255);
        // R7
        chk(get_be(rd + 4, 4) == longint'(m_glob), "R7 running count", get_be(rd + 4, 4), m_glob);
        // R8
        chk(get_be(rd + 8, 4) == longint'(m_wrap), "R8 wrapping count", get_be(rd + 8, 4), m_wrap);
        // R11: accumulation length field
        chk(get_be(rd + 1, 2) == longint'(len_field), "R11 length field", get_be(rd + 1, 2), len_field);
        ev = {8'd40, 16'(len_field), 8'(pnum), 32'(m_glob), 32'(m_wrap),
              delay_i[31:0], delay_i[63:32], delay_i[95:64], delay_i[127:96],
              fft_shift_i, adc_ovf_i, src_a_i, src_b_i, board_i, kind_i};
        mism = 0;
        for (int i = 0; i < HB; i++) begin
            if (cap_d[rd + i] !== ev[HB*8-1 - 8*i -: 8]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        end
        // R2: whole header image
        chk(mism == 0, "R2 header bytes", first_bad < 0 ? 0 : cap_d[rd + first_bad],
            first_bad < 0 ? 0 : ev[HB*8-1 - 8*first_bad -: 8]);
        mism = 0;
        for (int i = HB; i < len; i++) begin
            if (cap_d[rd + i] !== exp_dat) mism++;
            exp_dat = exp_dat + 8'd1;
        end
        // R4: payload order and content
        chk(mism == 0, "R4 payload bytes", mism, 0);
        rd += len;
    endtask

    task automatic run_acc(input int n, input int stall_at, input int chg_at);
        int npk = (n + FPP - 1) / FPP;
        clear_cap();
        acc_len_i = 16'(n);
        feed(n * BEATS, stall_at, chg_at);
        for (int p = 0; p < npk; p++) begin
            check_packet(n, p, (n - p * FPP) < FPP ? (n - p * FPP) : FPP);
        end
        // R3: packet count, no stray bytes
        chk(rd == wr, "R3 stream length", wr, rd);
        m_glob++;
        m_wrap = (m_wrap + 1) % WRAP;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        chk(!out_valid && !out_sop && !out_eop, "R1 outputs idle", out_valid, 0);
        chk(!in_ready, "R1 in_ready low", in_ready, 0);

        // Table walk: R1 (first packet counts zero), R2..R5, R10, R11
        for (int v = 0; v < NV; v++) begin
            delay_i     = {32'hA0000000 + 32'(v), 32'h00C0FFEE, 32'h12345678 + 32'(v), 32'h0000_2710 - 32'(v)};
            fft_shift_i = 32'h0000_0F0F ^ 32'(v);
            adc_ovf_i   = 32'(v * 1000 + 7);
            src_a_i     = 8'(TV_A[v]);
            src_b_i     = 8'(TV_B[v]);
            board_i     = 8'(v + 1);
            kind_i      = 8'(TV_KIND[v]);
            run_acc(TV_LEN[v], TV_STALL[v] * BEATS / 2, TV_CHG[v]);
        end

        // R6: index wraps past 255 in a 260-packet accumulation
        run_acc(1560, -1, -1);

        // R9: abort mid-accumulation with sync
        clear_cap();
        acc_len_i = 16'd13;
        feed(FPP * BEATS, -1, -1);
        check_packet(13, 0, FPP);
        @(negedge clk);
        sync_i = 1'b1;
        @(negedge clk);
        sync_i = 1'b0;
        m_wrap = 0;
        clear_cap();
        acc_len_i = 16'd1;
        feed(BEATS, -1, -1);
        check_packet(1, 0, 1);
        // R9: counts after sync
        chk(get_be(8, 4) == 0 && get_be(3, 1) == 0, "R9 cleared counts", get_be(8, 4), 0);
        chk(get_be(4, 4) == longint'(m_glob), "R9 running count kept", get_be(4, 4), m_glob);
        m_glob++;
        m_wrap = 1;

        // R8: wrapping count passes 49 back to 0
        for (int a = 0; a < WRAP; a++) run_acc(1, -1, -1);
        chk(m_wrap == 1, "R8 model wrapped", m_wrap, 1);

        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule